// File: doc/BRIEF.md
# Delayed Single-Tick Launch Channel

This block drives one timing output that goes high for exactly one helper-clock tick, a programmable number of ticks after the channel is launched. There are two ways to launch it. The host can ask for a pulse directly by writing the request bit. An external start event, such as a trigger accept that is already synchronous to the helper clock, can also launch it.

In single-cycle mode the external path is gated by an arm latch. The host arms the channel once, and only the next external start goes through. The host sees two read-only pending flags, one for a direct request and one for an arm. Any pulse from the channel clears both flags, whichever path caused it.

The host writes one register word each time `wr_en` is high. That word carries the delay, the request bit, the arm bit and the mode bit together. All logic runs on `clk`.

Top module: `launch_pulse_chan`

## Requirements
- R1: After reset, `pulse_out`, `pend_req` and `pend_arm` are 0. The stored delay is 0 and the stored mode is "every start".
- R2: A launch sampled at clock edge L drives `pulse_out` high at edge L+N+1 and low at edge L+N+2, where N is the delay field. For a host-request launch, N is the delay written in that same word. For an external launch, N is the stored delay.
- R3: A write with `wr_req`=1 launches the channel and sets `pend_req`. A later write with `wr_req`=0 clears `pend_req`, but it does not cancel a countdown that has already started.
- R4: When the stored mode bit is 0, every `ext_start` that arrives while the channel is idle launches it.
- R5: When the stored mode bit is 1, an `ext_start` launches the channel only if `pend_arm` is set. Once that pulse has occurred, a second `ext_start` does nothing.
- R6: A write with `wr_arm`=1 sets `pend_arm`. A later write with `wr_arm`=0 leaves `pend_arm` set, so the next start still launches the channel.
- R7: On the edge where `pulse_out` rises, both `pend_req` and `pend_arm` clear, whatever caused the pulse.
- R8: While a countdown runs, up to and including the edge where the pulse rises, any new launch stimulus is ignored and the countdown is not restarted.
- R9: `pulse_out` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Helper clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_delay | input | DLY_W | Launch-to-pulse delay field |
| wr_req | input | 1 | Immediate request bit |
| wr_arm | input | 1 | Single-cycle arm bit |
| wr_single | input | 1 | Single-cycle mode bit |
| ext_start | input | 1 | External start event, one tick wide, synchronous |
| pulse_out | output | 1 | One-tick output pulse |
| pend_req | output | 1 | Immediate request pending |
| pend_arm | output | 1 | Single-cycle arm pending |

## Verification
The hardest case to reach is a launch that lands on a busy channel. This includes a host request written in the middle of a countdown, which sets `pend_req` and must then be cleared by a pulse it did not cause.

The stimulus reaches it by timing the stimuli to the cycle. An external start begins a long countdown. A second start and a host request then follow a few ticks later. The scoreboard accepts exactly one pulse at the edge fixed by the first launch.

The same approach covers the arm-then-drop sequence. It also covers an arm that is cleared by a host-request pulse.

// File: rtl/launch_pulse_chan.sv
module launch_pulse_chan #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DLY_W-1:0] wr_delay,
  input  logic             wr_req,
  input  logic             wr_arm,
  input  logic             wr_single,
  input  logic             ext_start,
  output logic             pulse_out,
  output logic             pend_req,
  output logic             pend_arm
);

  logic [DLY_W-1:0] delay_q, cnt_q;
  logic             single_q, busy_q;

  wire fire      = busy_q && (cnt_q == '0);
  wire req_hit   = wr_en && wr_req;
  wire start_ok  = ext_start && (!single_q || pend_arm);
  wire launch    = !busy_q && (req_hit || start_ok);
  wire [DLY_W-1:0] load_val = wr_en ? wr_delay : delay_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q  <= '0;
      single_q <= 1'b0;
    end else if (wr_en) begin
      delay_q  <= wr_delay;
      single_q <= wr_single;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
    end else if (fire) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_out <= 1'b0;
      pend_req  <= 1'b0;
      pend_arm  <= 1'b0;
    end else begin
      pulse_out <= fire;
      if (fire)        pend_req <= 1'b0;
      else if (wr_en)  pend_req <= wr_req;
      if (fire)                 pend_arm <= 1'b0;
      else if (wr_en && wr_arm) pend_arm <= 1'b1;
    end
  end

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |=> !pulse_out);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> (!pend_req && !pend_arm));

  // R6
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_arm) |-> pulse_out);

  // R2
  pulse_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> !busy_q);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  // R5
  unarmed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && single_q && !pend_arm && !wr_en && ext_start) |=> !busy_q);

endmodule

// File: tb/launch_pulse_chan_tb_top.sv
`timescale 1ns/1ps
module launch_pulse_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_req = 1'b0, wr_arm = 1'b0, wr_single = 1'b0;
  logic [3:0] wr_delay = '0;
  logic       ext_start = 1'b0;
  logic       pulse_out, pend_req, pend_arm;

  int total = 0, bad = 0, cyc = 0;
  int exp_q[$];
  bit prev_pulse = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  launch_pulse_chan #(.DLY_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_delay(wr_delay),
    .wr_req(wr_req), .wr_arm(wr_arm), .wr_single(wr_single),
    .ext_start(ext_start), .pulse_out(pulse_out),
    .pend_req(pend_req), .pend_arm(pend_arm));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic hwrite(input int d, input bit rq, input bit am, input bit sg, input bit expect_launch);
    @(negedge clk);
    wr_en = 1'b1; wr_delay = 4'(d); wr_req = rq; wr_arm = am; wr_single = sg;
    if (expect_launch) exp_q.push_back(cyc + 2 + d);
    @(negedge clk);
    wr_en = 1'b0; wr_req = 1'b0; wr_arm = 1'b0;
  endtask

  task automatic xstart(input int d, input bit expect_launch);
    @(negedge clk);
    ext_start = 1'b1;
    if (expect_launch) exp_q.push_back(cyc + 2 + d);
    @(negedge clk);
    ext_start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse_out) begin
        if (prev_pulse) chk(1'b0, "R9 pulse width", 2, 1);
        if (exp_q.size() == 0) chk(1'b0, "R8/R5 unexpected pulse at cycle", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R2 pulse edge", cyc, e);
        end
      end
      prev_pulse = pulse_out;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(pulse_out == 1'b0, "R1 pulse_out", pulse_out, 0);
    chk(pend_req == 1'b0, "R1 pend_req", pend_req, 0);
    chk(pend_arm == 1'b0, "R1 pend_arm", pend_arm, 0);

    // R2 / R3 delays 0, 1, 15 via host request
    hwrite(0, 1, 0, 0, 1);
    chk(pend_req == 1'b1, "R3 pend_req set", pend_req, 1);
    idle(4);
    chk(pend_req == 1'b0, "R7 pend_req cleared d0", pend_req, 0);
    hwrite(1, 1, 0, 0, 1);
    idle(5);
    hwrite(15, 1, 0, 0, 1);
    idle(20);

    // R3 write 0 clears flag, countdown continues
    hwrite(15, 1, 0, 0, 1);
    hwrite(15, 0, 0, 0, 0);
    chk(pend_req == 1'b0, "R3 pend_req cleared by write", pend_req, 0);
    idle(20);

    // R4 every start launches in mode 0
    hwrite(5, 0, 0, 0, 0);
    xstart(5, 1);
    idle(10);
    xstart(5, 1);
    idle(10);

    // R8 busy ignores start and request; R7 pulse from start clears pend_req
    xstart(5, 1);
    xstart(5, 0);
    hwrite(5, 1, 0, 0, 0);
    chk(pend_req == 1'b1, "R8 pend_req set while busy", pend_req, 1);
    idle(10);
    chk(pend_req == 1'b0, "R7 pend_req cleared by start pulse", pend_req, 0);

    // R5 single mode unarmed start ignored
    hwrite(3, 0, 0, 1, 0);
    xstart(3, 0);
    idle(10);
    // R6 arm then drop
    hwrite(3, 0, 1, 1, 0);
    hwrite(3, 0, 0, 1, 0);
    chk(pend_arm == 1'b1, "R6 pend_arm held after drop", pend_arm, 1);
    xstart(3, 1);
    idle(10);
    chk(pend_arm == 1'b0, "R7 pend_arm cleared by pulse", pend_arm, 0);
    xstart(3, 0);
    idle(10);

    // R7 request pulse clears pending arm
    hwrite(3, 0, 1, 1, 0);
    chk(pend_arm == 1'b1, "R6 pend_arm set", pend_arm, 1);
    hwrite(2, 1, 0, 1, 1);
    idle(8);
    chk(pend_arm == 1'b0, "R7 pend_arm cleared by request pulse", pend_arm, 0);
    chk(pend_req == 1'b0, "R7 pend_req cleared", pend_req, 0);

    chk(exp_q.size() == 0, "R2 missing pulses", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule